// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address by reading a two-level translation table from memory. A requester presents a virtual address, an access kind (read, write or execute) and the physical base address of the top-level table. The walker reads the top-level entry, then the leaf entry, and answers with the physical address and the leaf's permission bits, or with a fault.

Both table levels hold 1024 four-byte entries, so each level fills exactly one 4 KiB page. Every entry keeps its frame number in bits 31:12 and its flag bits low in the word. A write that goes through a leaf whose dirty flag is still clear makes the walker store the leaf back to memory with that flag set before it answers. The memory port allows only one transaction in flight. Requests use a valid/ready handshake, and only one walk runs at a time.

Top module: `pt_walker`

## Requirements
- R1: The virtual address splits into a top-level index in bits 31:22, a leaf index in bits 21:12 and a byte offset in bits 11:0. The first read of a walk goes to `ptbr_i + 4 * top index`, using the base that was sampled when the request was accepted.
- R2: The second read goes to `{top entry bits 31:12, 12'h000} + 4 * leaf index`.
- R3: On success, `rsp_status_o` is 0 and `rsp_paddr_o` is `{leaf bits 31:12, byte offset}`. `rsp_perm_o` is `{execute, write, read}`, taken from leaf bits 3, 2 and 1.
- R4: When bit 0 (valid) of the top entry is clear, the walk ends after one read with status 1 (page fault). When bit 0 of the leaf is clear, it ends after two reads with status 1. In both cases the address and the permission bits are zero.
- R5: The access code is 0 for read, 1 for write, 2 for execute and 3 reserved. If the leaf's matching bit is clear, or the code is 3, the response has status 2 (protection fault), a zero address and the leaf's permission bits. No write-back takes place.
- R6: A write allowed by a leaf whose dirty bit (bit 4) is clear stores the leaf word with bit 4 set to the leaf's own address before the response. No other access stores anything.
- R7: `req_ready_o` is high only when the walker is idle. A request seen while a walk is running has no effect.
- R8: The memory port never issues a new request while a response is still outstanding.
- R9: During reset and right after it, `req_ready_o` is high and `rsp_valid_o` and `mem_req_o` are low.
- R10: `rsp_valid_o` stays high for exactly one cycle per walk. The status, address and permission outputs read zero while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle and accepting |
| req_vaddr_i | input | 32 | Virtual address |
| req_acc_i | input | 2 | Access code: 0 read, 1 write, 2 execute, 3 reserved |
| ptbr_i | input | 32 | Physical base address of the top-level table |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_status_o | output | 2 | 0 ok, 1 page fault, 2 protection fault |
| rsp_paddr_o | output | 32 | Physical address on success |
| rsp_perm_o | output | 3 | Leaf {execute, write, read} |
| mem_req_o | output | 1 | Memory request strobe |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Memory word address |
| mem_wdata_o | output | 32 | Write data (leaf with dirty set) |
| mem_rsp_valid_i | input | 1 | Memory read data or write acknowledge |
| mem_rdata_i | input | 32 | Memory read data |

## Verification
The hardest case to reach from the ports is a write-back that is interleaved with memory latency while a second request stays asserted through the whole walk. Only a write through a clean leaf creates the third transaction, and the stalled request must stay out until the response pulse has gone. The stimulus walks the same clean leaf twice with a write, changing the memory latency between walks, so the first walk stores the dirty bit and the second one must not. A directed test keeps `req_valid_i` high with a different address across a whole walk, releases it in the response cycle, and then checks that no further memory traffic appears.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned OFF_W  = 12;
  localparam int unsigned IDX_W  = 10;
  localparam int unsigned PPN_W  = ADDR_W - OFF_W;
  localparam int unsigned ENT_LG = 2;  // log2 of entry bytes

  localparam int unsigned BIT_V = 0;
  localparam int unsigned BIT_R = 1;
  localparam int unsigned BIT_W = 2;
  localparam int unsigned BIT_X = 3;
  localparam int unsigned BIT_D = 4;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    ST_OK         = 2'd0,
    ST_PAGE_FAULT = 2'd1,
    ST_PROT_FAULT = 2'd2
  } status_e;

  typedef enum logic [2:0] {
    W_IDLE,
    W_DIR_REQ,
    W_DIR_WAIT,
    W_LEAF_REQ,
    W_LEAF_WAIT,
    W_WB_REQ,
    W_WB_WAIT,
    W_RESP
  } walk_state_e;
endpackage

// File: rtl/pt_mem_addr.sv
module pt_mem_addr #(
  parameter int unsigned AW = 32,
  parameter int unsigned OW = 12,
  parameter int unsigned IW = 10,
  parameter int unsigned EL = 2
) (
  input  logic [AW-1:0]    base_i,
  input  logic [AW-OW-1:0] dir_ppn_i,
  input  logic [IW-1:0]    dir_idx_i,
  input  logic [IW-1:0]    leaf_idx_i,
  input  logic             leaf_sel_i,
  output logic [AW-1:0]    addr_o
);
  localparam int unsigned PADW = AW - IW - EL;

  logic [AW-1:0] dir_off, leaf_off, tbl_base;

  assign dir_off  = {{PADW{1'b0}}, dir_idx_i, {EL{1'b0}}};
  assign leaf_off = {{PADW{1'b0}}, leaf_idx_i, {EL{1'b0}}};
  assign tbl_base = {dir_ppn_i, {OW{1'b0}}};
  assign addr_o   = leaf_sel_i ? (tbl_base + leaf_off) : (base_i + dir_off);
endmodule

// File: rtl/pt_perm_chk.sv
module pt_perm_chk
  import pt_walker_pkg::*;
(
  input  logic    valid_i,
  input  logic    rd_i,
  input  logic    wr_i,
  input  logic    ex_i,
  input  logic    dirty_i,
  input  acc_e    acc_i,
  output status_e status_o,
  output logic    need_wb_o
);
  logic allowed;

  always_comb begin
    unique case (acc_i)
      ACC_READ:  allowed = rd_i;
      ACC_WRITE: allowed = wr_i;
      ACC_EXEC:  allowed = ex_i;
      default:   allowed = 1'b0;
    endcase
  end

  always_comb begin
    if (!valid_i)      status_o = ST_PAGE_FAULT;
    else if (!allowed) status_o = ST_PROT_FAULT;
    else               status_o = ST_OK;
  end

  assign need_wb_o = valid_i && allowed && (acc_i == ACC_WRITE) && !dirty_i;
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walker_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic        mem_rsp_valid_i,
  input  logic        dir_valid_i,
  input  status_e     leaf_status_i,
  input  logic        leaf_wb_i,
  output walk_state_e state_o,
  output logic        req_ready_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic        leaf_sel_o,
  output logic        rsp_valid_o,
  output status_e     status_o
);
  walk_state_e state_q, state_d;
  status_e     status_q, status_d;

  always_comb begin
    state_d  = state_q;
    status_d = status_q;
    unique case (state_q)
      W_IDLE:     if (req_valid_i) state_d = W_DIR_REQ;
      W_DIR_REQ:  state_d = W_DIR_WAIT;
      W_DIR_WAIT: if (mem_rsp_valid_i) begin
        if (!dir_valid_i) begin
          status_d = ST_PAGE_FAULT;
          state_d  = W_RESP;
        end else begin
          state_d  = W_LEAF_REQ;
        end
      end
      W_LEAF_REQ:  state_d = W_LEAF_WAIT;
      W_LEAF_WAIT: if (mem_rsp_valid_i) begin
        status_d = leaf_status_i;
        state_d  = leaf_wb_i ? W_WB_REQ : W_RESP;
      end
      W_WB_REQ:  state_d = W_WB_WAIT;
      W_WB_WAIT: if (mem_rsp_valid_i) state_d = W_RESP;
      W_RESP:    state_d = W_IDLE;
      default:   state_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= W_IDLE;
      status_q <= ST_OK;
    end else begin
      state_q  <= state_d;
      status_q <= status_d;
    end
  end

  assign state_o     = state_q;
  assign status_o    = status_q;
  assign req_ready_o = (state_q == W_IDLE);
  assign mem_req_o   = (state_q == W_DIR_REQ) || (state_q == W_LEAF_REQ) || (state_q == W_WB_REQ);
  assign mem_we_o    = (state_q == W_WB_REQ);
  assign leaf_sel_o  = (state_q == W_LEAF_REQ) || (state_q == W_WB_REQ);
  assign rsp_valid_o = (state_q == W_RESP);

  p_rsp_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  p_busy_after_accept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [31:0] req_vaddr_i,
  input  logic [1:0]  req_acc_i,
  input  logic [31:0] ptbr_i,
  output logic        rsp_valid_o,
  output logic [1:0]  rsp_status_o,
  output logic [31:0] rsp_paddr_o,
  output logic [2:0]  rsp_perm_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic        mem_rsp_valid_i,
  input  logic [31:0] mem_rdata_i
);
  logic [ADDR_W-1:0] vaddr_q, base_q, leaf_q;
  logic [PPN_W-1:0]  dir_ppn_q;
  acc_e              acc_q;
  walk_state_e       state;
  status_e           status, leaf_status;
  logic              leaf_wb, leaf_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vaddr_q   <= '0;
      base_q    <= '0;
      acc_q     <= ACC_READ;
      dir_ppn_q <= '0;
      leaf_q    <= '0;
    end else begin
      if (req_valid_i && req_ready_o) begin
        vaddr_q <= req_vaddr_i;
        base_q  <= ptbr_i;
        acc_q   <= acc_e'(req_acc_i);
      end
      if (state == W_DIR_WAIT && mem_rsp_valid_i) dir_ppn_q <= mem_rdata_i[ADDR_W-1:OFF_W];
      if (state == W_LEAF_WAIT && mem_rsp_valid_i) leaf_q <= mem_rdata_i;
    end
  end

  pt_walk_ctrl u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .mem_rsp_valid_i(mem_rsp_valid_i),
    .dir_valid_i    (mem_rdata_i[BIT_V]),
    .leaf_status_i  (leaf_status),
    .leaf_wb_i      (leaf_wb),
    .state_o        (state),
    .req_ready_o    (req_ready_o),
    .mem_req_o      (mem_req_o),
    .mem_we_o       (mem_we_o),
    .leaf_sel_o     (leaf_sel),
    .rsp_valid_o    (rsp_valid_o),
    .status_o       (status)
  );

  // judged on the incoming leaf word during the leaf wait
  pt_perm_chk u_perm (
    .valid_i  (mem_rdata_i[BIT_V]),
    .rd_i     (mem_rdata_i[BIT_R]),
    .wr_i     (mem_rdata_i[BIT_W]),
    .ex_i     (mem_rdata_i[BIT_X]),
    .dirty_i  (mem_rdata_i[BIT_D]),
    .acc_i    (acc_q),
    .status_o (leaf_status),
    .need_wb_o(leaf_wb)
  );

  pt_mem_addr #(
    .AW(ADDR_W), .OW(OFF_W), .IW(IDX_W), .EL(ENT_LG)
  ) u_addr (
    .base_i    (base_q),
    .dir_ppn_i (dir_ppn_q),
    .dir_idx_i (vaddr_q[ADDR_W-1 -: IDX_W]),
    .leaf_idx_i(vaddr_q[OFF_W +: IDX_W]),
    .leaf_sel_i(leaf_sel),
    .addr_o    (mem_addr_o)
  );

  assign mem_wdata_o = leaf_q | (ADDR_W'(1) << BIT_D);

  assign rsp_status_o = rsp_valid_o ? status : 2'b00;
  assign rsp_paddr_o  = (rsp_valid_o && status == ST_OK)
                        ? {leaf_q[ADDR_W-1:OFF_W], vaddr_q[OFF_W-1:0]} : '0;
  assign rsp_perm_o   = (rsp_valid_o && status != ST_PAGE_FAULT)
                        ? {leaf_q[BIT_X], leaf_q[BIT_W], leaf_q[BIT_R]} : 3'b000;

  // outstanding-transaction tracker for the port check
  logic outst_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              outst_q <= 1'b0;
    else if (mem_req_o)       outst_q <= 1'b1;
    else if (mem_rsp_valid_i) outst_q <= 1'b0;
  end

  p_single_outstanding_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outst_q |-> !mem_req_o);

  p_wb_sets_dirty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_wdata_o[BIT_D] && mem_wdata_o[BIT_V] && acc_q == ACC_WRITE));

  p_fault_no_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o == 2'd1) |-> (rsp_paddr_o == '0 && rsp_perm_o == '0));

  p_prot_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o == 2'd0 && acc_q == ACC_READ) |-> rsp_perm_o[0]);
endmodule

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_vaddr_i = '0;
  logic [1:0]  req_acc_i = '0;
  logic [31:0] ptbr_i = '0;
  logic        rsp_valid_o;
  logic [1:0]  rsp_status_o;
  logic [31:0] rsp_paddr_o;
  logic [2:0]  rsp_perm_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pt_walker dut_i (.*);

  int checks = 0;
  int errors = 0;

  // memory model
  logic [31:0] mem [logic [31:0]];
  int          lat = 1;
  int          rd_cnt = 0, wr_cnt = 0;
  logic [31:0] last_rd = '0, prev_rd = '0, last_wa = '0, last_wd = '0;
  logic        m_busy = 1'b0;
  int          m_cnt = 0;
  logic [31:0] m_val = '0;

  always @(posedge clk_i) begin
    mem_rsp_valid_i <= 1'b0;
    if (m_busy) begin
      if (m_cnt <= 1) begin
        mem_rsp_valid_i <= 1'b1;
        mem_rdata_i     <= m_val;
        m_busy          <= 1'b0;
      end else begin
        m_cnt <= m_cnt - 1;
      end
    end else if (mem_req_o) begin
      m_busy <= 1'b1;
      m_cnt  <= lat;
      if (mem_we_o) begin
        mem[mem_addr_o] = mem_wdata_o;
        wr_cnt  = wr_cnt + 1;
        last_wa = mem_addr_o;
        last_wd = mem_wdata_o;
        m_val  <= '0;
      end else begin
        rd_cnt  = rd_cnt + 1;
        prev_rd = last_rd;
        last_rd = mem_addr_o;
        m_val  <= mem.exists(mem_addr_o) ? mem[mem_addr_o] : 32'h0;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_walk(input logic [31:0] va, input logic [1:0] acc, input logic [31:0] base,
                          output logic [1:0] st, output logic [31:0] pa, output logic [2:0] pm);
    logic rdy;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_vaddr_i = va; req_acc_i = acc; ptbr_i = base;
    forever begin
      rdy = req_ready_o;
      @(posedge clk_i);
      if (rdy) break;
      @(negedge clk_i);
    end
    @(negedge clk_i);
    req_valid_i = 1'b0;
    while (!rsp_valid_o) @(negedge clk_i);
    st = rsp_status_o; pa = rsp_paddr_o; pm = rsp_perm_o;
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  acc;
    logic [1:0]  st;
    logic [31:0] pa;
    logic [2:0]  perm;
    logic        wb;
    logic [1:0]  nrd;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{32'h7192a44c, 2'd0, 2'd0, 32'h1481744c, 3'b011, 1'b0, 2'd2},
    '{32'h7192a44c, 2'd1, 2'd0, 32'h1481744c, 3'b011, 1'b1, 2'd2},
    '{32'h7192a44c, 2'd1, 2'd0, 32'h1481744c, 3'b011, 1'b0, 2'd2},
    '{32'h71801abc, 2'd0, 2'd0, 32'h22222abc, 3'b001, 1'b0, 2'd2},
    '{32'h71801abc, 2'd1, 2'd2, 32'h00000000, 3'b001, 1'b0, 2'd2},
    '{32'h71801abc, 2'd2, 2'd2, 32'h00000000, 3'b001, 1'b0, 2'd2},
    '{32'h71803ffc, 2'd2, 2'd0, 32'h33333ffc, 3'b101, 1'b0, 2'd2},
    '{32'h71802010, 2'd0, 2'd1, 32'h00000000, 3'b000, 1'b0, 2'd2},
    '{32'h00000123, 2'd0, 2'd1, 32'h00000000, 3'b000, 1'b0, 2'd1},
    '{32'h71803ffc, 2'd1, 2'd2, 32'h00000000, 3'b101, 1'b0, 2'd2},
    '{32'h71803ffc, 2'd3, 2'd2, 32'h00000000, 3'b101, 1'b0, 2'd2}
  };

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL R7 watchdog actual=hung expected=done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0]  st;
    logic [31:0] pa;
    logic [2:0]  pm;
    int r0, w0;

    // table at 0x10000; top entry 0x1c6 -> table 0x12345000
    mem[32'h00010718] = 32'h12345001;
    mem[32'h123454a8] = 32'h14817007;  // v r w, clean
    mem[32'h12345004] = 32'h22222003;  // v r
    mem[32'h12345008] = 32'h00000000;  // invalid
    mem[32'h1234500c] = 32'h3333300b;  // v r x
    // second table at 0x20000 -> table 0x40000000
    mem[32'h00020718] = 32'h40000001;
    mem[32'h400004a8] = 32'h55555013;  // v r d

    repeat (3) @(negedge clk_i);
    check("R9 ready in reset", 32'(req_ready_o), 32'd1);
    check("R9 rsp idle in reset", 32'(rsp_valid_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R9 mem idle after reset", 32'(mem_req_o), 32'd0);
    check("R10 outputs zero when idle", {rsp_paddr_o[28:0], rsp_status_o, rsp_perm_o[0]}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      lat = (i % 3) + 1;
      r0 = rd_cnt; w0 = wr_cnt;
      run_walk(VECS[i].va, VECS[i].acc, 32'h00010000, st, pa, pm);
      check($sformatf("R3/R4/R5 status v%0d", i), 32'(st), 32'(VECS[i].st));
      check($sformatf("R3 paddr v%0d", i), pa, VECS[i].pa);
      check($sformatf("R3 perm v%0d", i), 32'(pm), 32'(VECS[i].perm));
      @(negedge clk_i);
      check($sformatf("R10 single pulse v%0d", i), 32'(rsp_valid_o), 32'd0);
      check($sformatf("R6 writes v%0d", i), 32'(wr_cnt - w0), 32'(VECS[i].wb));
      check($sformatf("R4 reads v%0d", i), 32'(rd_cnt - r0), 32'(VECS[i].nrd));
      if (i == 1) begin
        check("R6 wb address", last_wa, 32'h123454a8);
        check("R6 wb data", last_wd, 32'h14817017);
      end
      if (i == 0) begin
        check("R1 top entry address", prev_rd, 32'h00010718);
        check("R2 leaf address", last_rd, 32'h123454a8);
      end
    end

    // R1/R2: new base selects a different table
    lat = 2;
    run_walk(32'h7192a44c, 2'd0, 32'h00020000, st, pa, pm);
    check("R1 top entry address new base", prev_rd, 32'h00020718);
    check("R2 leaf address new base", last_rd, 32'h400004a8);
    check("R3 paddr new base", pa, 32'h5555544c);
    check("R3 perm new base", 32'(pm), 32'd1);

    // R7: request held during busy is ignored
    @(negedge clk_i);
    req_valid_i = 1'b1; req_vaddr_i = 32'h7192a44c; req_acc_i = 2'd0; ptbr_i = 32'h00010000;
    @(posedge clk_i);
    @(negedge clk_i);
    req_vaddr_i = 32'h00000123;
    check("R7 ready low while busy", 32'(req_ready_o), 32'd0);
    while (!rsp_valid_o) @(negedge clk_i);
    check("R7 first request served", rsp_paddr_o, 32'h1481744c);
    req_valid_i = 1'b0;
    r0 = rd_cnt;
    repeat (6) @(negedge clk_i);
    check("R7 busy request dropped", 32'(rd_cnt - r0), 32'd0);
    check("R7 ready back", 32'(req_ready_o), 32'd1);

    // R6: clean leaf written again on a write after restoring it clean
    mem[32'h123454a8] = 32'h14817007;
    lat = 3;
    w0 = wr_cnt;
    run_walk(32'h7192a44c, 2'd1, 32'h00010000, st, pa, pm);
    check("R6 wb under long latency", 32'(wr_cnt - w0), 32'd1);
    check("R6 stored dirty", mem[32'h123454a8], 32'h14817017);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule